// File: doc/BRIEF.md
# Dual-Sided Configurable Control/Status Register

This block is one storage register that two parties share. Software writes through a data bus with a write enable and reads with a read enable. Hardware logic can overwrite the value with its own data and write enable. Both sides see the stored value at once. An access-model parameter fixes what a software write does to the stored bits:

- `CSR_RO` ignores software writes.
- `CSR_RW` loads the software data.
- `CSR_W1C`, `CSR_W0C`, `CSR_W1S` and `CSR_W0S` clear or set the bits selected by ones or by zeros in the written data.

The width and the reset value are also parameters.

The hardware side also receives two single-cycle strobes, one for software reads and one for software writes. These let surrounding logic react to an access. Examples are popping a queue on a read or starting an action on a write. Both busy flags are always 0, because every access completes in its own cycle.

Top module: `dual_port_csr`

## Requirements
- R1: An active-low asynchronous reset loads the stored value with parameter `INIT` at once, without waiting for a clock edge, and drives both access strobes low.
- R2: With `MODEL == CSR_RO`, a software write leaves the stored value unchanged. A hardware write loads `hw_wdata` on the next rising edge.
- R3: With `MODEL == CSR_RW`, a software write loads `sw_wdata` on the next edge. When both sides write in the same cycle, the software data is stored.
- R4: With `MODEL == CSR_W1C`, each bit that is 1 in `sw_wdata` is cleared. Bits that are 0 keep their value.
- R5: With `MODEL == CSR_W0C`, each bit that is 0 in `sw_wdata` is cleared. Bits that are 1 keep their value.
- R6: With `MODEL == CSR_W1S`, each bit that is 1 in `sw_wdata` is set. Other bits keep their value.
- R7: With `MODEL == CSR_W0S`, each bit that is 0 in `sw_wdata` is set. Other bits keep their value.
- R8: In the four set/clear models, a hardware write in the same cycle as a software write is applied first. The software mask is then applied to the hardware data.
- R9: In any model, a cycle with neither write enable holds the value. A hardware write alone stores `hw_wdata`.
- R10: `sw_rdata` and `hw_rdata` both equal the stored value in the same cycle, with no added latency.
- R11: `sw_rbusy` and `sw_wbusy` are always 0.
- R12: `hw_sw_read` is high for exactly the cycle after each cycle in which `sw_ren` was high, and low otherwise.
- R13: `hw_sw_write` is high for exactly the cycle after each cycle in which `sw_wen` was high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_wdata | input | W | Software write data or mask |
| sw_wen | input | 1 | Software write enable |
| sw_ren | input | 1 | Software read enable |
| hw_wdata | input | W | Hardware write data |
| hw_wen | input | 1 | Hardware write enable |
| sw_rdata | output | W | Stored value, software view |
| sw_rbusy | output | 1 | Read busy, tied 0 |
| sw_wbusy | output | 1 | Write busy, tied 0 |
| hw_rdata | output | W | Stored value, hardware view |
| hw_sw_read | output | 1 | One-cycle pulse after a software read |
| hw_sw_write | output | 1 | One-cycle pulse after a software write |

## Verification
Each result is due at a fixed point after its stimulus:

- A write of either kind shows in the stored value one rising edge after the cycle in which its enables were applied.
- The two access strobes also rise one edge after their enable.
- The read outputs follow the stored value in the same cycle.
- Reset acts with no edge at all.

The bench changes inputs just after a falling edge, lets exactly one rising edge pass, and compares at the next falling edge against its own per-bit model. It does this for all six access models side by side. For reset, it samples one time unit after asserting it.

// File: rtl/csr_pkg.sv
package csr_pkg;
  // Software write semantics of the register.
  typedef enum logic [2:0] {
    CSR_RO  = 3'd0,
    CSR_RW  = 3'd1,
    CSR_W1C = 3'd2,
    CSR_W0C = 3'd3,
    CSR_W1S = 3'd4,
    CSR_W0S = 3'd5
  } csr_model_e;
endpackage

// File: rtl/csr_next_value.sv
module csr_next_value #(
  parameter int unsigned W = 1,
  parameter csr_pkg::csr_model_e MODEL = csr_pkg::CSR_RW
) (
  input  logic [W-1:0] cur_q,
  input  logic         sw_we,
  input  logic [W-1:0] sw_wd,
  input  logic         hw_we,
  input  logic [W-1:0] hw_wd,
  output logic [W-1:0] next_q,
  output logic         load
);
  import csr_pkg::*;

  // Hardware data (if any) forms the base that software then acts on.
  function automatic logic [W-1:0] base_of(logic [W-1:0] q, logic hwe, logic [W-1:0] hwd);
    return hwe ? hwd : q;
  endfunction

  function automatic logic [W-1:0] apply_sw(csr_model_e m, logic [W-1:0] b,
                                            logic swe, logic [W-1:0] swd);
    logic [W-1:0] r;
    r = b;
    if (swe) begin
      case (m)
        CSR_RW:  r = swd;
        CSR_W1C: r = b & ~swd;
        CSR_W0C: r = b & swd;
        CSR_W1S: r = b | swd;
        CSR_W0S: r = b | ~swd;
        default: r = b;
      endcase
    end
    return r;
  endfunction

  always_comb begin
    next_q = apply_sw(MODEL, base_of(cur_q, hw_we, hw_wd), sw_we, sw_wd);
    load   = hw_we | sw_we;
  end
endmodule

// File: rtl/csr_storage.sv
module csr_storage #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= INIT;
    else if (load) q <= d;
  end
endmodule

// File: rtl/csr_access_events.sv
module csr_access_events (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic wr_en,
  output logic rd_seen,
  output logic wr_seen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_seen <= 1'b0;
      wr_seen <= 1'b0;
    end else begin
      rd_seen <= rd_en;
      wr_seen <= wr_en;
    end
  end
endmodule

// File: rtl/dual_port_csr.sv
module dual_port_csr #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0,
  parameter csr_pkg::csr_model_e MODEL = csr_pkg::CSR_RW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sw_wdata,
  input  logic         sw_wen,
  input  logic         sw_ren,
  input  logic [W-1:0] hw_wdata,
  input  logic         hw_wen,
  output logic [W-1:0] sw_rdata,
  output logic         sw_rbusy,
  output logic         sw_wbusy,
  output logic [W-1:0] hw_rdata,
  output logic         hw_sw_read,
  output logic         hw_sw_write
);
  // Named internal events, visible to the checker.
  logic [W-1:0] stored_q;
  logic [W-1:0] update_d;
  logic         update_en;

  csr_next_value #(.W(W), .MODEL(MODEL)) u_next (
    .cur_q (stored_q),
    .sw_we (sw_wen),
    .sw_wd (sw_wdata),
    .hw_we (hw_wen),
    .hw_wd (hw_wdata),
    .next_q(update_d),
    .load  (update_en)
  );

  csr_storage #(.W(W), .INIT(INIT)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .load (update_en),
    .d    (update_d),
    .q    (stored_q)
  );

  csr_access_events u_events (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (sw_ren),
    .wr_en  (sw_wen),
    .rd_seen(hw_sw_read),
    .wr_seen(hw_sw_write)
  );

  assign sw_rdata = stored_q;
  assign hw_rdata = stored_q;
  assign sw_rbusy = 1'b0;
  assign sw_wbusy = 1'b0;
endmodule

// File: rtl/csr_checker.sv
module csr_checker #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0,
  parameter csr_pkg::csr_model_e MODEL = csr_pkg::CSR_RW
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] sw_wdata,
  input logic         sw_wen,
  input logic         sw_ren,
  input logic [W-1:0] hw_wdata,
  input logic         hw_wen,
  input logic [W-1:0] sw_rdata,
  input logic         sw_rbusy,
  input logic         sw_wbusy,
  input logic [W-1:0] hw_rdata,
  input logic         hw_sw_read,
  input logic         hw_sw_write
);
  import csr_pkg::*;

  // R1
  reset_value_chk: assert property (@(posedge clk) !rst_n |-> (hw_rdata == INIT && !hw_sw_read && !hw_sw_write));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wen && !hw_wen) |=> $stable(hw_rdata));

  // R10
  views_equal_chk: assert property (@(posedge clk) disable iff (!rst_n) sw_rdata == hw_rdata);

  // R11
  never_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) !sw_rbusy && !sw_wbusy);

  // R12
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) sw_ren |=> hw_sw_read);
  // R12
  read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !sw_ren |=> !hw_sw_read);

  // R13
  write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) sw_wen |=> hw_sw_write);
  // R13
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !sw_wen |=> !hw_sw_write);

  generate
    if (MODEL == CSR_RO) begin : g_ro
      // R2
      ro_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wen && !hw_wen) |=> $stable(hw_rdata));
    end
    if (MODEL == CSR_RW) begin : g_rw
      // R3
      rw_sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wen |=> hw_rdata == $past(sw_wdata));
    end
    if (MODEL == CSR_W1C) begin : g_w1c
      // R4
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wen |=> (hw_rdata & $past(sw_wdata)) == '0);
    end
    if (MODEL == CSR_W1S) begin : g_w1s
      // R6
      w1s_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wen |=> (hw_rdata & $past(sw_wdata)) == $past(sw_wdata));
    end
  endgenerate
endmodule

bind dual_port_csr csr_checker #(.W(W), .INIT(INIT), .MODEL(MODEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_wdata(sw_wdata), .sw_wen(sw_wen), .sw_ren(sw_ren),
  .hw_wdata(hw_wdata), .hw_wen(hw_wen), .sw_rdata(sw_rdata), .sw_rbusy(sw_rbusy),
  .sw_wbusy(sw_wbusy), .hw_rdata(hw_rdata), .hw_sw_read(hw_sw_read), .hw_sw_write(hw_sw_write)
);

// File: tb/tb_dual_port_csr.sv
module tb_dual_port_csr;
  import csr_pkg::*;

  localparam int unsigned W = 8;
  localparam logic [W-1:0] INIT = 8'hA5;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [W-1:0] sw_wdata = '0;
  logic sw_wen = 1'b0;
  logic sw_ren = 1'b0;
  logic [W-1:0] hw_wdata = '0;
  logic hw_wen = 1'b0;

  logic [W-1:0] srd [NM];
  logic [W-1:0] hrd [NM];
  logic         rbz [NM];
  logic         wbz [NM];
  logic         rst [NM];
  logic         wst [NM];

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Index 0..5 = RW, RO, W1C, W0C, W1S, W0S
  dual_port_csr #(.W(W), .INIT(INIT), .MODEL(CSR_RW)) dut (
    .clk(clk), .rst_n(rst_n), .sw_wdata(sw_wdata), .sw_wen(sw_wen), .sw_ren(sw_ren),
    .hw_wdata(hw_wdata), .hw_wen(hw_wen), .sw_rdata(srd[0]), .sw_rbusy(rbz[0]),
    .sw_wbusy(wbz[0]), .hw_rdata(hrd[0]), .hw_sw_read(rst[0]), .hw_sw_write(wst[0]));
  dual_port_csr #(.W(W), .INIT(INIT), .MODEL(CSR_RO)) dut_ro (
    .clk(clk), .rst_n(rst_n), .sw_wdata(sw_wdata), .sw_wen(sw_wen), .sw_ren(sw_ren),
    .hw_wdata(hw_wdata), .hw_wen(hw_wen), .sw_rdata(srd[1]), .sw_rbusy(rbz[1]),
    .sw_wbusy(wbz[1]), .hw_rdata(hrd[1]), .hw_sw_read(rst[1]), .hw_sw_write(wst[1]));
  dual_port_csr #(.W(W), .INIT(INIT), .MODEL(CSR_W1C)) dut_w1c (
    .clk(clk), .rst_n(rst_n), .sw_wdata(sw_wdata), .sw_wen(sw_wen), .sw_ren(sw_ren),
    .hw_wdata(hw_wdata), .hw_wen(hw_wen), .sw_rdata(srd[2]), .sw_rbusy(rbz[2]),
    .sw_wbusy(wbz[2]), .hw_rdata(hrd[2]), .hw_sw_read(rst[2]), .hw_sw_write(wst[2]));
  dual_port_csr #(.W(W), .INIT(INIT), .MODEL(CSR_W0C)) dut_w0c (
    .clk(clk), .rst_n(rst_n), .sw_wdata(sw_wdata), .sw_wen(sw_wen), .sw_ren(sw_ren),
    .hw_wdata(hw_wdata), .hw_wen(hw_wen), .sw_rdata(srd[3]), .sw_rbusy(rbz[3]),
    .sw_wbusy(wbz[3]), .hw_rdata(hrd[3]), .hw_sw_read(rst[3]), .hw_sw_write(wst[3]));
  dual_port_csr #(.W(W), .INIT(INIT), .MODEL(CSR_W1S)) dut_w1s (
    .clk(clk), .rst_n(rst_n), .sw_wdata(sw_wdata), .sw_wen(sw_wen), .sw_ren(sw_ren),
    .hw_wdata(hw_wdata), .hw_wen(hw_wen), .sw_rdata(srd[4]), .sw_rbusy(rbz[4]),
    .sw_wbusy(wbz[4]), .hw_rdata(hrd[4]), .hw_sw_read(rst[4]), .hw_sw_write(wst[4]));
  dual_port_csr #(.W(W), .INIT(INIT), .MODEL(CSR_W0S)) dut_w0s (
    .clk(clk), .rst_n(rst_n), .sw_wdata(sw_wdata), .sw_wen(sw_wen), .sw_ren(sw_ren),
    .hw_wdata(hw_wdata), .hw_wen(hw_wen), .sw_rdata(srd[5]), .sw_rbusy(rbz[5]),
    .sw_wbusy(wbz[5]), .hw_rdata(hrd[5]), .hw_sw_read(rst[5]), .hw_sw_write(wst[5]));

  logic [W-1:0] exp_q [NM];
  logic exp_rs, exp_ws;

  // Per-bit reference of each model, written independently of the RTL.
  function automatic logic [W-1:0] ref_next(int m, logic [W-1:0] q, logic swe,
                                            logic [W-1:0] swd, logic hwe, logic [W-1:0] hwd);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      logic b;
      b = hwe ? hwd[i] : q[i];
      if (swe) begin
        case (m)
          0: b = swd[i];
          2: if (swd[i])  b = 1'b0;
          3: if (!swd[i]) b = 1'b0;
          4: if (swd[i])  b = 1'b1;
          5: if (!swd[i]) b = 1'b1;
          default: ;
        endcase
      end
      r[i] = b;
    end
    return r;
  endfunction

  function automatic string req_of(int m);
    case (m)
      0: return "R3";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic check_all(string tag);
    for (int m = 0; m < NM; m++) begin
      chk(hrd[m] === exp_q[m], {req_of(m), " ", tag}, hrd[m], exp_q[m]);
      chk(srd[m] === exp_q[m], {"R10 ", tag}, srd[m], exp_q[m]);
      chk(rbz[m] === 1'b0 && wbz[m] === 1'b0, "R11", {6'd0, rbz[m], wbz[m]}, '0);
      chk(rst[m] === exp_rs, "R12", {7'd0, rst[m]}, {7'd0, exp_rs});
      chk(wst[m] === exp_ws, "R13", {7'd0, wst[m]}, {7'd0, exp_ws});
    end
  endtask

  // Apply one cycle of stimulus, advance one rising edge, check at falling edge.
  task automatic step(logic swe, logic [W-1:0] swd, logic sre, logic hwe,
                      logic [W-1:0] hwd, string tag);
    sw_wen = swe; sw_wdata = swd; sw_ren = sre; hw_wen = hwe; hw_wdata = hwd;
    @(posedge clk);
    for (int m = 0; m < NM; m++) exp_q[m] = ref_next(m, exp_q[m], swe, swd, hwe, hwd);
    exp_rs = sre;
    exp_ws = swe;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    sw_wen = 0; sw_ren = 0; hw_wen = 0;
    rst_n = 1'b0;
    #1;
    for (int m = 0; m < NM; m++) exp_q[m] = INIT;
    exp_rs = 0; exp_ws = 0;
    check_all({"R1 ", tag});
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    #1 rst_n = 1'b0;
    for (int m = 0; m < NM; m++) exp_q[m] = INIT;
    exp_rs = 0; exp_ws = 0;
    @(negedge clk);
    check_all("R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // R9 idle hold
    step(0, 8'hFF, 0, 0, 8'h00, "R9 idle");
    // R9 hardware alone
    step(0, 8'h00, 0, 1, 8'h3C, "R9 hw only");
    // R2..R7 software alone, mask 0x0F
    step(1, 8'h0F, 0, 0, 8'h00, "sw mask 0F");
    // R8 collision: hw then software mask; R3 software wins
    step(1, 8'hF0, 1, 1, 8'h5A, "R8 collide");
    // R12 read only
    step(0, 8'h00, 1, 0, 8'h00, "R12 read");
    // R13 back to back writes with all-ones and all-zeros
    step(1, 8'hFF, 0, 0, 8'h00, "R13 ones");
    step(1, 8'h00, 0, 0, 8'h00, "R13 zeros");
    step(1, 8'h00, 1, 1, 8'hC3, "R8 zero mask collide");

    // R1 asynchronous reset mid-run
    do_reset("mid-run");

    for (int n = 0; n < 600; n++) begin
      step(1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), "random");
    end

    step(0, 8'h00, 0, 0, 8'h00, "R9 final idle");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule